// File: doc/BRIEF.md
# Permuted DRAM Bank Mapper with Open-Row Tracking

This block turns a physical byte address into a DRAM bank, row and column, and labels each access by the state of that bank's row buffer. The column is the low address slice and covers one row buffer. The row is the high address slice. The bank is not taken straight from the slice that sits between them. That slice also feeds the cache set index, so addresses that collide in the cache tend to land in the same bank with different rows. To avoid this, the slice is XORed with an equal-width group of bits from the tag region. That group lies inside the row field, so every byte of one page still reaches a single row of a single bank.

The block keeps an open-row record for each bank, as an open-page controller does. Each access is reported as one of three cases: a hit on the open row, an access to an idle bank, or a conflict that needs a precharge. The bank then records the new row as open. A per-bank close mask tells the block that the controller has precharged a bank. The controller that issues commands sits downstream and uses the class to pick its command sequence. The tag field position is a parameter, and elaboration stops if that field overlaps the bank or column fields.

Top module: `xpm_bank_mapper`

## Requirements
- R1: Every cycle with `req_valid` high produces exactly one cycle of `rsp_valid` on the next clock edge. `rsp_valid` is low in every other cycle and while reset is held.
- R2: `rsp_col` equals address bits [COL_W-1:0], and `rsp_row` equals address bits [ADDR_W-1:COL_W+BANK_W]. With the defaults these are bits [10:0] and [31:16].
- R3: `rsp_bank` equals address bits [COL_W+BANK_W-1:COL_W] XOR bits [TAG_LSB+BANK_W-1:TAG_LSB]. With the defaults this is [15:11] XOR [25:21].
- R4: Two addresses that differ only in column bits map to the same bank and the same row. Two addresses with the same conventional bank bits but different tag-field bits map to different banks.
- R5: An access whose bank has an open row equal to the access row is classed 2'b00 (row hit).
- R6: An access to a bank with no open row is classed 2'b01 (idle bank). This covers every bank after reset and any bank closed by `close_mask`. The code 2'b11 is never produced.
- R7: An access to a bank whose open row differs from the access row is classed 2'b10 (conflict). After any access, the accessed row is the open row of its bank.
- R8: A set bit b of `close_mask` removes bank b's open row at the clock edge. If an access to bank b arrives in the same cycle, it is classed against the state before that edge, and the bank is left open on the access row.
- R9: A close of one bank has no effect on the open row of any other bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Address strobe |
| req_addr | input | ADDR_W | Physical byte address |
| close_mask | input | NUM_BANKS | Per-bank precharge notification, one bit per bank |
| rsp_valid | output | 1 | Result valid, one cycle after the strobe |
| rsp_bank | output | BANK_W | Permuted bank index |
| rsp_row | output | ROW_W | Row address |
| rsp_col | output | COL_W | Column (byte within row buffer) |
| rsp_class | output | 2 | 00 row hit, 01 idle bank, 10 conflict |

## Verification
The assertions check the following on every cycle:
- the one-cycle strobe-to-result relation and the column pass-through;
- that exactly one of the three internal class events fires for each access;
- that the class code is always legal;
- that two consecutive results on the same bank give a hit when the row repeats and a conflict when it changes.

Other behaviour needs the bench's directed scenarios. These cover the exact XOR mapping, and the spreading of addresses that share conventional bank bits. They also cover the state an idle bank enters after an explicit close, the precedence rule when a close and an access meet in one cycle, and the isolation of a close from other banks.

// File: rtl/xpm_pkg.sv
package xpm_pkg;
  // Row-buffer classification codes; the downstream controller decodes these.
  typedef enum logic [1:0] {
    ACC_HIT      = 2'b00,
    ACC_IDLE     = 2'b01,
    ACC_CONFLICT = 2'b10
  } acc_class_e;
endpackage

// File: rtl/xpm_addr_split.sv
module xpm_addr_split #(
  parameter int ADDR_W  = 32,
  parameter int COL_W   = 11,
  parameter int BANK_W  = 5,
  parameter int TAG_LSB = 21,
  localparam int ROW_W  = ADDR_W - COL_W - BANK_W
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [BANK_W-1:0] bank,
  output logic [ROW_W-1:0]  row,
  output logic [COL_W-1:0]  col
);
  // R3: conventional bank slice folded with a slice of the tag region
  function automatic logic [BANK_W-1:0] permute_bank(input logic [ADDR_W-1:0] a);
    return a[COL_W +: BANK_W] ^ a[TAG_LSB +: BANK_W];
  endfunction

  // R2: row is everything above the bank slice
  function automatic logic [ROW_W-1:0] row_of(input logic [ADDR_W-1:0] a);
    return a[COL_W+BANK_W +: ROW_W];
  endfunction

  function automatic logic [COL_W-1:0] col_of(input logic [ADDR_W-1:0] a);
    return a[COL_W-1:0];
  endfunction

  assign bank = permute_bank(addr);
  assign row  = row_of(addr);
  assign col  = col_of(addr);
endmodule

// File: rtl/xpm_row_table.sv
module xpm_row_table #(
  parameter int NUM_BANKS = 32,
  parameter int ROW_W     = 16,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 acc_valid,
  input  logic [BANK_W-1:0]    acc_bank,
  input  logic [ROW_W-1:0]     acc_row,
  input  logic [NUM_BANKS-1:0] close_mask,
  output logic                 lkp_open,
  output logic [ROW_W-1:0]     lkp_row
);
  logic [NUM_BANKS-1:0] open_vld;
  logic [ROW_W-1:0]     open_row [NUM_BANKS];

  // Lookup uses the state before the current edge (R8)
  assign lkp_open = open_vld[acc_bank];
  assign lkp_row  = open_row[acc_bank];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_vld <= '0;
      for (int b = 0; b < NUM_BANKS; b++) open_row[b] <= '0;
    end else begin
      for (int b = 0; b < NUM_BANKS; b++) begin
        if (acc_valid && acc_bank == BANK_W'(b)) begin
          // R7/R8: an access leaves its row open and beats a close in the same cycle
          open_vld[b] <= 1'b1;
          open_row[b] <= acc_row;
        end else if (close_mask[b]) begin
          // R8/R9: only the flagged bank loses its row
          open_vld[b] <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/xpm_bank_mapper.sv
module xpm_bank_mapper #(
  parameter int ADDR_W    = 32,
  parameter int NUM_BANKS = 32,
  parameter int ROW_BYTES = 2048,
  parameter int TAG_LSB   = 21,
  localparam int BANK_W   = $clog2(NUM_BANKS),
  localparam int COL_W    = $clog2(ROW_BYTES),
  localparam int ROW_W    = ADDR_W - COL_W - BANK_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [NUM_BANKS-1:0] close_mask,
  output logic                 rsp_valid,
  output logic [BANK_W-1:0]    rsp_bank,
  output logic [ROW_W-1:0]     rsp_row,
  output logic [COL_W-1:0]     rsp_col,
  output logic [1:0]           rsp_class
);
  import xpm_pkg::*;

  // The tag slice must lie wholly inside the row field
  localparam bit TAG_FIELD_OK = (TAG_LSB >= COL_W + BANK_W) && (TAG_LSB + BANK_W <= ADDR_W);
  if (!TAG_FIELD_OK) begin : g_tag_field_bad
    $error("xpm_bank_mapper: tag slice overlaps bank/column fields or exceeds address width");
  end

  logic [BANK_W-1:0] acc_bank;
  logic [ROW_W-1:0]  acc_row;
  logic [COL_W-1:0]  acc_col;
  logic              lkp_open;
  logic [ROW_W-1:0]  lkp_row;

  xpm_addr_split #(
    .ADDR_W(ADDR_W), .COL_W(COL_W), .BANK_W(BANK_W), .TAG_LSB(TAG_LSB)
  ) u_split (
    .addr(req_addr), .bank(acc_bank), .row(acc_row), .col(acc_col)
  );

  xpm_row_table #(
    .NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W)
  ) u_table (
    .clk(clk), .rst_n(rst_n),
    .acc_valid(req_valid), .acc_bank(acc_bank), .acc_row(acc_row),
    .close_mask(close_mask),
    .lkp_open(lkp_open), .lkp_row(lkp_row)
  );

  // Named classification events, observed by the checker
  logic hit_w, idle_w, conflict_w;
  assign idle_w     = !lkp_open;
  assign hit_w      = lkp_open && (lkp_row == acc_row);
  assign conflict_w = lkp_open && (lkp_row != acc_row);

  acc_class_e cls_d;
  always_comb begin
    if (idle_w)     cls_d = ACC_IDLE;
    else if (hit_w) cls_d = ACC_HIT;
    else            cls_d = ACC_CONFLICT;
  end

  // R1: one register stage from strobe to result
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_bank  <= '0;
      rsp_row   <= '0;
      rsp_col   <= '0;
      rsp_class <= 2'b00;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_bank  <= acc_bank;
        rsp_row   <= acc_row;
        rsp_col   <= acc_col;
        rsp_class <= cls_d;
      end
    end
  end
endmodule

// File: rtl/xpm_bank_mapper_chk.sv
module xpm_bank_mapper_chk #(
  parameter int ADDR_W = 32,
  parameter int NUM_BANKS = 32,
  parameter int BANK_W = 5,
  parameter int COL_W  = 11,
  parameter int ROW_W  = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 req_valid,
  input logic [ADDR_W-1:0]    req_addr,
  input logic [NUM_BANKS-1:0] close_mask,
  input logic                 rsp_valid,
  input logic [BANK_W-1:0]    rsp_bank,
  input logic [ROW_W-1:0]     rsp_row,
  input logic [COL_W-1:0]     rsp_col,
  input logic [1:0]           rsp_class,
  input logic                 hit_w,
  input logic                 idle_w,
  input logic                 conflict_w
);
  a_r1_resp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid));

  a_r2_col_pass: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_col == $past(req_addr[COL_W-1:0]));

  a_r5_one_class: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> $countones({hit_w, idle_w, conflict_w}) == 1);

  a_r6_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_class != 2'b11);

  a_r5_repeat_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && $past(rsp_valid) && rsp_bank == $past(rsp_bank) && rsp_row == $past(rsp_row))
      |-> rsp_class == 2'b00);

  a_r7_row_change: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && $past(rsp_valid) && rsp_bank == $past(rsp_bank) && rsp_row != $past(rsp_row))
      |-> rsp_class == 2'b10);
endmodule

bind xpm_bank_mapper xpm_bank_mapper_chk #(
  .ADDR_W(ADDR_W), .NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .COL_W(COL_W), .ROW_W(ROW_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
  .close_mask(close_mask), .rsp_valid(rsp_valid), .rsp_bank(rsp_bank),
  .rsp_row(rsp_row), .rsp_col(rsp_col), .rsp_class(rsp_class),
  .hit_w(hit_w), .idle_w(idle_w), .conflict_w(conflict_w)
);

// File: tb/xpm_bank_mapper_tb.sv
module xpm_bank_mapper_tb;
  localparam int AW = 32;
  localparam int NB = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [NB-1:0] close_mask = '0;
  logic          rsp_valid;
  logic [4:0]    rsp_bank;
  logic [15:0]   rsp_row;
  logic [10:0]   rsp_col;
  logic [1:0]    rsp_class;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  // Bench model of open rows
  bit          m_open [NB];
  logic [15:0] m_row  [NB];

  always #10 clk = ~clk;

  xpm_bank_mapper u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .close_mask(close_mask), .rsp_valid(rsp_valid), .rsp_bank(rsp_bank),
    .rsp_row(rsp_row), .rsp_col(rsp_col), .rsp_class(rsp_class)
  );

  // Bank: bits 15:11 folded with tag bits 25:21
  function automatic logic [4:0] e_bank(input logic [31:0] a);
    logic [4:0] r;
    for (int i = 0; i < 5; i++) r[i] = a[11+i] ^ a[21+i];
    return r;
  endfunction

  function automatic logic [15:0] e_row(input logic [31:0] a);
    return a >> 16;
  endfunction

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // One access, optionally with a close mask in the same cycle; checks all outputs
  task automatic access(input logic [31:0] a, input logic [NB-1:0] cm, input string req);
    logic [4:0]  b = e_bank(a);
    logic [15:0] r = e_row(a);
    logic [1:0]  ec;
    if (!m_open[b])        ec = 2'b01;
    else if (m_row[b] == r) ec = 2'b00;
    else                    ec = 2'b10;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; close_mask = cm;
    @(negedge clk);
    req_valid = 1'b0; close_mask = '0;
    for (int i = 0; i < NB; i++) if (cm[i]) m_open[i] = 0;
    m_open[b] = 1; m_row[b] = r;
    check(req, "valid", 32'(rsp_valid), 32'd1);
    check(req, "bank",  32'(rsp_bank), 32'(b));
    check(req, "row",   32'(rsp_row), 32'(r));
    check(req, "col",   32'(rsp_col), 32'(a[10:0]));
    check(req, "class", 32'(rsp_class), 32'(ec));
  endtask

  task automatic close_banks(input logic [NB-1:0] cm);
    @(negedge clk);
    close_mask = cm;
    @(negedge clk);
    close_mask = '0;
    for (int i = 0; i < NB; i++) if (cm[i]) m_open[i] = 0;
  endtask

  task automatic t_reset;
    check("R1", "valid in reset", 32'(rsp_valid), 32'd0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check("R1", "valid idle after reset", 32'(rsp_valid), 32'd0);
  endtask

  task automatic t_mapping;
    access(32'h0000_0000, '0, "R6 first access idle");
    access(32'h1234_5ABC, '0, "R3 mapping");
    access(32'hFFFF_FFFF, '0, "R2 all ones");
    access(32'h03E0_F800, '0, "R3 fold to zero");
    check("R3", "fold result", 32'(rsp_bank), 32'd0);
    @(negedge clk);
    check("R1", "single-cycle valid", 32'(rsp_valid), 32'd0);
  endtask

  task automatic t_locality;
    access(32'h00A0_4010, '0, "R4 page first");
    access(32'h00A0_47F0, '0, "R4 R5 same page hit");
    check("R5", "class hit", 32'(rsp_class), 32'd0);
  endtask

  task automatic t_spread;
    logic [4:0] b1;
    access(32'h0100_0800, '0, "R4 spread a");
    b1 = rsp_bank;
    access(32'h0120_0800, '0, "R4 spread b");
    n_run++;
    if (b1 == rsp_bank) begin
      n_fail++;
      $display("FAIL R4 spread: actual %0h expected differing from %0h", rsp_bank, b1);
    end
  endtask

  task automatic t_conflict;
    access(32'h0005_1000, '0, "R7 open");
    access(32'h0006_1000, '0, "R7 conflict");
    check("R7", "class conflict", 32'(rsp_class), 32'd2);
    access(32'h0006_1234, '0, "R7 new row now open");
    check("R7", "class hit after conflict", 32'(rsp_class), 32'd0);
  endtask

  task automatic t_close;
    access(32'h0007_1800, '0, "R8 open");
    close_banks(32'(1) << e_bank(32'h0007_1800));
    access(32'h0007_1800, '0, "R6 R8 after close");
    check("R6", "class idle after close", 32'(rsp_class), 32'd1);
  endtask

  task automatic t_close_other;
    access(32'h0009_2000, '0, "R9 open");
    close_banks(~(32'(1) << e_bank(32'h0009_2000)));
    access(32'h0009_2004, '0, "R9 untouched bank");
    check("R9", "class hit", 32'(rsp_class), 32'd0);
  endtask

  task automatic t_same_cycle;
    logic [4:0] b = e_bank(32'h000B_2800);
    access(32'h000B_2800, '0, "R8 open");
    access(32'h000C_2800, 32'(1) << b, "R8 close with access");
    check("R8", "class uses prior state", 32'(rsp_class), 32'd2);
    access(32'h000C_2808, '0, "R8 access wins");
    check("R8", "bank stays open", 32'(rsp_class), 32'd0);
  endtask

  initial begin
    for (int i = 0; i < NB; i++) begin m_open[i] = 0; m_row[i] = '0; end
    repeat (3) @(negedge clk);
    t_reset();
    t_mapping();
    t_locality();
    t_spread();
    t_conflict();
    t_close();
    t_close_other();
    t_same_cycle();
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      done = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule